// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block drives several PWM outputs from a single free-running counter. The counter climbs from zero to a programmed period value and then restarts at zero, so every output repeats with one common period. The period slot is the highest channel index, and it is not an output. Each lower channel holds a threshold. Its output stays low while the count is under the threshold and goes high from the threshold to the end of the period.

Thresholds arrive over a small write port that carries a channel index and a value. A write aimed at the period slot is refused and raises an error pulse. Accepted values sit in a pending register and reach the comparator only at the next period boundary, or at once while the counter is stopped. This keeps a running waveform free of glitches. Each channel can also latch a sticky flag when the count meets its threshold. The interrupt line is the OR of all flags, and software clears flags one by one.

All pins are plain control and status signals. No data stream crosses the boundary, so there is no back-pressure.

Top module: `pwm_shared_period`

## Requirements
- R1: While `en` is high, the count advances by one per clock from 0 up to `period` and returns to 0 on the clock after it equals `period`. While `en` is low, the count is cleared to 0 and held there.
- R2: `pwm[c]` is high exactly when `pwm_en[c]` is high and the count is greater than or equal to the channel's active threshold. A threshold of 0 gives a constant high output.
- R3: A threshold greater than `period` gives a constant low output.
- R4: An accepted write reaches the comparator at the next period boundary, which is the clock on which the count returns to 0. While `en` is low, it takes effect on the clock that stores it.
- R5: A write with `wr_chan` equal to NCH (3 by default, the period slot) changes no threshold. It raises `wr_err` for exactly the one cycle after the write.
- R6: If `irq_en[c]` and `pwm_en[c]` are high and the running count equals the active threshold, `flags[c]` is set on the next clock and stays set. `irq` is the OR of `flags`.
- R7: A high `flag_clr[c]` clears `flags[c]` on the next clock, unless a new match sets it on that same clock. A new match wins.
- R8: With `pwm_en[c]` low, `pwm[c]` stays low and `flags[c]` is never set.
- R9: With `irq_en[c]` low, `flags[c]` is never set, while `pwm[c]` still toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counter run enable |
| period | input | CNT_W | Last count value of each period |
| wr_en | input | 1 | Threshold write strobe |
| wr_chan | input | SEL_W | Channel index of the write; NCH is the period slot and is rejected |
| wr_value | input | CNT_W | Threshold value to write |
| pwm_en | input | NCH | Per-channel output enable |
| irq_en | input | NCH | Per-channel flag enable |
| flag_clr | input | NCH | Per-channel flag clear, one bit per flag |
| pwm | output | NCH | PWM outputs |
| flags | output | NCH | Sticky match flags |
| irq | output | 1 | OR of all flags |
| wr_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The outputs follow the count combinationally, so `pwm` for count value j is read in the cycle the counter holds j. That is j clocks after `en` rises, with the expected value computed as (j mod (period+1)) >= threshold. A flag shows up one clock after its matching count, so the bench expects it from sample index threshold+1 onward. `wr_err` and flag clears are read exactly one clock after the stimulus. A threshold rewritten mid-period is expected to keep its old value through that period's last count and to change at sample period+1. Inputs change and outputs are sampled just after the falling edge, well clear of the rising edge.

// File: rtl/pwm_shared_pkg.sv
package pwm_shared_pkg;
  // per-channel control bits gathered for one comparator
  typedef struct packed {
    logic out_en;
    logic irq_en;
    logic clr;
  } ch_ctl_t;
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             load
);
  logic at_end;
  assign at_end = (cnt >= period);
  // thresholds may move in while stopped or on the last count of a period
  assign load = !en || at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!en)         cnt <= '0;
    else if (at_end)      cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt >= period) |=> (cnt == '0));
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt < period) |=> (cnt == $past(cnt) + 1'b1));
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/pwm_match_channel.sv
module pwm_match_channel
  import pwm_shared_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             load,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_value,
  input  ch_ctl_t          ctl,
  output logic             pwm,
  output logic             flag
);
  logic [CNT_W-1:0] pend_q, pend_d, active_q;
  logic             match;

  assign pend_d = wr ? wr_value : pend_q;
  assign match  = en && ctl.out_en && (cnt == active_q);
  assign pwm    = ctl.out_en && (cnt >= active_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      active_q <= '0;
      flag     <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (load) active_q <= pend_d;
      flag <= (match && ctl.irq_en) || (flag && !ctl.clr);
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q));
  assert_flagset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match && ctl.irq_en) |=> flag);
  assert_noirq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.irq_en && !flag) |=> !flag);
  assert_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.out_en |-> !pwm);
endmodule

// File: rtl/pwm_shared_period.sv
module pwm_shared_period
  import pwm_shared_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NCH   = 3,
  localparam int SEL_W = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_chan,
  input  logic [CNT_W-1:0] wr_value,
  input  logic [NCH-1:0]   pwm_en,
  input  logic [NCH-1:0]   irq_en,
  input  logic [NCH-1:0]   flag_clr,
  output logic [NCH-1:0]   pwm,
  output logic [NCH-1:0]   flags,
  output logic             irq,
  output logic             wr_err
);
  logic [CNT_W-1:0] cnt;
  logic             load;
  logic             bad_wr;

  pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period),
    .cnt(cnt), .load(load)
  );

  // indices at or past NCH address the period slot, never a comparator
  assign bad_wr = wr_en && (wr_chan >= SEL_W'(NCH));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ch_ctl_t ctl;
    logic    hit;
    assign ctl = '{out_en: pwm_en[c], irq_en: irq_en[c], clr: flag_clr[c]};
    assign hit = wr_en && (wr_chan == SEL_W'(c));
    pwm_match_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .load(load),
      .wr(hit), .wr_value(wr_value), .ctl(ctl),
      .pwm(pwm[c]), .flag(flags[c])
    );
  end

  assign irq = |flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= bad_wr;
  end

  assert_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> wr_err);
  assert_errsrc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en));
endmodule

// File: tb/test_pwm_shared_period.sv
module test_pwm_shared_period;
  localparam int W = 8;
  localparam int N = 3;
  logic clk = 0, rst_n = 0, en = 0, wr_en = 0, irq, wr_err;
  logic [W-1:0] period = 0, wr_value = 0;
  logic [1:0] wr_chan = 0;
  logic [N-1:0] pwm_en = 0, irq_en = 0, flag_clr = 0, pwm, flags;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pwm_shared_period #(.CNT_W(W), .NCH(N)) i_pwm_shared_period (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .wr_en(wr_en),
    .wr_chan(wr_chan), .wr_value(wr_value), .pwm_en(pwm_en), .irq_en(irq_en),
    .flag_clr(flag_clr), .pwm(pwm), .flags(flags), .irq(irq), .wr_err(wr_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input int ch, input int v);
    wr_en = 1; wr_chan = 2'(ch); wr_value = W'(v);
    tick();
    wr_en = 0;
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0, p1, p2, ex;
    tick(); tick();
    chk("R1 reset pwm", pwm, 0);
    chk("R6 reset flags", flags, 0);
    chk("R5 reset wr_err", wr_err, 0);
    rst_n = 1;
    tick();

    // sweep over periods and thresholds
    pwm_en = 3'b011; irq_en = 3'b001;
    for (int p = 0; p <= 6; p++) begin
      for (int a = 0; a <= p + 1; a++) begin
        p0 = a; p1 = (a + 1) % (p + 2); p2 = p + 1 - a;
        en = 0; period = W'(p); flag_clr = 3'b111;
        tick();
        wr(0, p0); wr(1, p1); wr(2, p2);
        flag_clr = 0;
        en = 1; #1;
        for (int j = 0; j < 2 * (p + 1) + 1; j++) begin
          ex = ((j % (p + 1)) >= p0) ? 1 : 0;
          chk(p0 == 0 ? "R2 zero threshold" : (p0 > p ? "R3 above period" : "R2 compare ch0"), pwm[0], ex);
          chk("R1 R2 ch1", pwm[1], ((j % (p + 1)) >= p1) ? 1 : 0);
          chk("R8 disabled ch2 pwm", pwm[2], 0);
          ex = (p0 <= p && j > p0) ? 1 : 0;
          chk("R6 flag ch0", flags[0], ex);
          chk("R6 irq", irq, ex);
          chk("R9 no flag ch1", flags[1], 0);
          chk("R8 no flag ch2", flags[2], 0);
          tick(); #1;
        end
      end
    end

    // mid-period rewrite
    en = 0; period = 7; pwm_en = 3'b001; irq_en = 0;
    tick();
    wr(0, 2);
    en = 1; #1;
    for (int j = 0; j < 16; j++) begin
      ex = ((j % 8) >= (j < 8 ? 2 : 6)) ? 1 : 0;
      chk("R4 update at boundary", pwm[0], ex);
      if (j == 3) begin wr_en = 1; wr_chan = 0; wr_value = 6; end
      tick(); #1;
      wr_en = 0;
    end

    // rejected write to period slot; count is now 0 (j=16)
    wr_en = 1; wr_chan = 3; wr_value = 0;
    tick();
    wr_en = 0;
    chk("R5 wr_err pulse", wr_err, 1);
    tick();
    chk("R5 wr_err one cycle", wr_err, 0);
    for (int j = 2; j < 12; j++) begin
      chk("R5 threshold unchanged", pwm[0], ((j % 8) >= 6) ? 1 : 0);
      tick();
    end

    // flag clear and set-wins
    en = 0; period = 3; pwm_en = 3'b001; irq_en = 3'b001; flag_clr = 3'b001;
    tick();
    flag_clr = 0;
    wr(0, 1);
    en = 1; #1;
    tick(); tick();
    chk("R6 flag after match", flags[0], 1);
    flag_clr = 3'b001;
    tick();
    flag_clr = 0;
    chk("R7 flag cleared", flags[0], 0);
    chk("R7 irq cleared", irq, 0);
    tick(); tick();
    flag_clr = 3'b001;
    tick();
    flag_clr = 0;
    chk("R7 set wins over clear", flags[0], 1);

    // stopped counter and immediate load
    en = 0; flag_clr = 3'b001;
    tick();
    flag_clr = 0;
    for (int j = 0; j < 3; j++) begin
      chk("R1 held at zero", pwm[0], 0);
      chk("R1 no match while stopped", flags[0], 0);
      tick();
    end
    wr(0, 0);
    chk("R4 immediate load while stopped", pwm[0], 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule